// File: doc/BRIEF.md
# PCI Configuration Cycle Router

This block sits on a host I/O port and implements configuration access mechanism #1. A full 32-bit write to I/O port 0CF8h loads an address latch. The latch holds an enable bit, a bus number, a device number, a function number and a dword register index. Any access to the data window at I/O 0CFCh–0CFFh then turns into one configuration cycle, built from the current latch contents and sent to one of three targets.

The three targets are the internal configuration registers, a downstream hub link and a bridged graphics port. Routing depends on three things: the bus number, the internal-device enable inputs, and the bridge's secondary and subordinate bus numbers. Hub and graphics requests carry a cycle-type flag that marks Type 0 or Type 1. The host port takes one request at a time and answers it with a one-cycle response pulse that carries the read data.

The controller is a five-state machine:

- **ST_IDLE** accepts a request.
- **ST_WAIT_INT**, **ST_WAIT_HUB** and **ST_WAIT_GFX** hold the request to the chosen target until that target's `done` pulse arrives.
- **ST_RESP** presents the response.

Transitions:

- **ST_IDLE → ST_WAIT_x** on an enabled data-window access, where x is the decoded route.
- **ST_IDLE → ST_RESP** on any other access: a latch access, a disabled data-window access or an unclaimed address.
- **ST_WAIT_x → ST_RESP** when target x asserts `done`.
- **ST_RESP → ST_IDLE** always.

Top module: `cfg_cycle_router`

## Requirements
- R1: After reset the address latch reads as 0, no target request is active, `io_resp_valid` is 0 and `io_req_ready` is 1.
- R2: A write to the latch dword (io_addr 0CF8h–0CFBh) with all four byte enables set loads the latch, and a read of that dword returns the latch with bits 1:0 forced to 0. A latch write with any byte enable clear leaves the latch unchanged.
- R3: When latch bit 31 is 0, a data-window access (0CFCh–0CFFh) issues no target request, and a read returns FFFF_FFFFh.
- R4: With bit 31 set, bus 0 and device 0 or 1 whose `int_dev_en` bit (bit index = device number) is 1 goes to the internal target, with the type flag at 0.
- R5: With bit 31 set, bus 0 and device 0 or 1 whose enable bit is 0 goes to the hub link as Type 0.
- R6: With bit 31 set, bus 0 and a device number of 2 or more goes to the hub link as Type 0.
- R7: With bit 31 set, a non-zero bus below `sec_bus` or above `sub_bus` goes to the hub link as Type 1. The comparison is unsigned 8-bit.
- R8: With bit 31 set, a non-zero bus with sec_bus ≤ bus ≤ sub_bus goes to the graphics port. It is Type 0 when bus equals `sec_bus` and Type 1 otherwise.
- R9: A forwarded cycle carries the following fields:
  - bus = latch bits 23:16
  - device = latch bits 15:11
  - function = latch bits 10:8
  - register index = latch bits 7:2
  - byte enables, write flag and write data taken from the host access.
- R10: At most one target request is active at a time. It stays asserted until that target's `done`. The cycle after `done`, `io_resp_valid` pulses with that target's read data.
- R11: An access to any address outside the two dwords issues no target request, does not change the latch, and a read of it returns FFFF_FFFFh.
- R12: `io_req_ready` is 1 only in ST_IDLE, so a second request is not taken while one is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req_valid | input | 1 | Host I/O request present |
| io_req_ready | output | 1 | Request accepted this cycle when high together with valid |
| io_write | input | 1 | 1 = I/O write, 0 = I/O read |
| io_addr | input | ADDR_W | Host I/O byte address |
| io_be | input | 4 | Byte lane enables |
| io_wdata | input | 32 | Write data |
| io_resp_valid | output | 1 | One-cycle response pulse |
| io_rdata | output | 32 | Read data, valid with io_resp_valid |
| int_dev_en | input | N_INT_DEV | Enable per internal bus-0 device |
| sec_bus | input | 8 | Bridge secondary bus number |
| sub_bus | input | 8 | Bridge subordinate bus number |
| int_req | output | 1 | Request to internal configuration registers |
| hub_req | output | 1 | Request to hub link |
| gfx_req | output | 1 | Request to graphics port |
| tgt_write | output | 1 | Forwarded cycle is a write |
| tgt_type1 | output | 1 | Forwarded cycle is Type 1 |
| tgt_bus | output | 8 | Forwarded bus number |
| tgt_dev | output | 5 | Forwarded device number |
| tgt_func | output | 3 | Forwarded function number |
| tgt_reg | output | 6 | Forwarded dword register index |
| tgt_be | output | 4 | Forwarded byte enables |
| tgt_wdata | output | 32 | Forwarded write data |
| int_done | input | 1 | Internal target completion pulse |
| int_rdata | input | 32 | Internal target read data |
| hub_done | input | 1 | Hub link completion pulse |
| hub_rdata | input | 32 | Hub link read data |
| gfx_done | input | 1 | Graphics port completion pulse |
| gfx_rdata | input | 32 | Graphics port read data |

## Verification
The hardest situations to reach are the two range edges, where the bus equals `sec_bus` or equals `sub_bus`. Also hard is a disabled internal device, which must fall through to the hub link rather than being claimed internally. The directed tasks reach these cases as follows:

- They program `sec_bus`/`sub_bus` to a narrow window.
- They load the latch with buses just outside the window, on each edge and inside it.
- They clear one `int_dev_en` bit and repeat a bus-0 access.

The bench's target models answer after a fixed delay. Each check therefore compares the target that was requested, the type flag and the read data that came back.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

    localparam int BUS_W = 8;
    localparam int DEV_W = 5;
    localparam int FN_W  = 3;
    localparam int REG_W = 6;

    typedef struct packed {
        logic             en;
        logic [6:0]       rsvd;
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  func;
        logic [REG_W-1:0] regn;
        logic [1:0]       lo;
    } cfg_addr_t;

    typedef enum logic [1:0] {
        RT_INT  = 2'd0,
        RT_HUB  = 2'd1,
        RT_GFX  = 2'd2,
        RT_NONE = 2'd3
    } route_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_INT = 3'd1,
        ST_WAIT_HUB = 3'd2,
        ST_WAIT_GFX = 3'd3,
        ST_RESP     = 3'd4
    } state_e;

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
    import cfg_router_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [3:0]        wr_be,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_addr_t         q
);

    localparam int BE_W = DATA_W / 8;

    logic full_dword;
    assign full_dword = &wr_be[BE_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr && full_dword) begin
            q    <= cfg_addr_t'(wr_data);
            q.lo <= 2'b00;
        end
    end

    // a partial write must leave the latch untouched
    assert_partial_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !full_dword) |=> $stable(q));

endmodule

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
    import cfg_router_pkg::*;
#(
    parameter int N_INT_DEV = 2
) (
    input  cfg_addr_t            addr,
    input  logic [BUS_W-1:0]     sec_bus,
    input  logic [BUS_W-1:0]     sub_bus,
    input  logic [N_INT_DEV-1:0] int_dev_en,
    output route_e               route,
    output logic                 type1
);

    logic [N_INT_DEV-1:0] dev_hit;
    logic                 int_hit;
    logic                 bus_zero;
    logic                 in_window;

    genvar g;
    generate
        for (g = 0; g < N_INT_DEV; g++) begin : g_intdev
            assign dev_hit[g] = (addr.dev == DEV_W'(g)) && int_dev_en[g];
        end
    endgenerate

    assign int_hit   = |dev_hit;
    assign bus_zero  = (addr.bus == '0);
    assign in_window = (addr.bus >= sec_bus) && (addr.bus <= sub_bus);

    always_comb begin
        route = RT_HUB;
        type1 = 1'b0;
        if (!addr.en) begin
            route = RT_NONE;
        end else if (bus_zero) begin
            route = int_hit ? RT_INT : RT_HUB;
        end else if (in_window) begin
            route = RT_GFX;
            type1 = (addr.bus != sec_bus);
        end else begin
            route = RT_HUB;
            type1 = 1'b1;
        end
    end

endmodule

// File: rtl/cfg_router_fsm.sv
module cfg_router_fsm
    import cfg_router_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req_valid,
    output logic              io_req_ready,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [3:0]        io_be,
    input  logic [31:0]       io_wdata,
    output logic              io_resp_valid,
    output logic [31:0]       io_rdata,
    input  cfg_addr_t         latch_q,
    output logic              latch_wr,
    input  route_e            route,
    input  logic              route_t1,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic [2:0]        tgt_req,
    output logic              tgt_write,
    output logic              tgt_type1,
    output logic [BUS_W-1:0]  tgt_bus,
    output logic [DEV_W-1:0]  tgt_dev,
    output logic [FN_W-1:0]   tgt_func,
    output logic [REG_W-1:0]  tgt_reg,
    output logic [3:0]        tgt_be,
    output logic [31:0]       tgt_wdata,
    input  logic [2:0]        tgt_done,
    input  logic [95:0]       tgt_rdata
);

    state_e state, state_nx;
    logic   accept, hit_addr, hit_data, fwd;
    logic   [31:0] resp_q;

    assign hit_addr = (io_addr[ADDR_W-1:2] == ADDR_PORT[ADDR_W-1:2]);
    assign hit_data = (io_addr[ADDR_W-1:2] == DATA_PORT[ADDR_W-1:2]);
    assign accept   = (state == ST_IDLE) && io_req_valid;
    assign fwd      = hit_data && latch_q.en && (route != RT_NONE);
    assign latch_wr = accept && io_write && hit_addr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (io_req_valid) begin
                    if (fwd) begin
                        unique case (route)
                            RT_INT:  state_nx = ST_WAIT_INT;
                            RT_GFX:  state_nx = ST_WAIT_GFX;
                            default: state_nx = ST_WAIT_HUB;
                        endcase
                    end else begin
                        state_nx = ST_RESP;
                    end
                end
            end
            ST_WAIT_INT: if (tgt_done[0]) state_nx = ST_RESP;
            ST_WAIT_HUB: if (tgt_done[1]) state_nx = ST_RESP;
            ST_WAIT_GFX: if (tgt_done[2]) state_nx = ST_RESP;
            ST_RESP:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        io_req_ready  = (state == ST_IDLE);
        io_resp_valid = (state == ST_RESP);
        io_rdata      = resp_q;
        tgt_req       = 3'b000;
        unique case (state)
            ST_WAIT_INT: tgt_req = 3'b001;
            ST_WAIT_HUB: tgt_req = 3'b010;
            ST_WAIT_GFX: tgt_req = 3'b100;
            default:     tgt_req = 3'b000;
        endcase
    end

    // payload and response data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q    <= '1;
            tgt_write <= 1'b0;
            tgt_type1 <= 1'b0;
            tgt_bus   <= '0;
            tgt_dev   <= '0;
            tgt_func  <= '0;
            tgt_reg   <= '0;
            tgt_be    <= '0;
            tgt_wdata <= '0;
        end else begin
            if (accept) begin
                resp_q <= (hit_addr && !io_write) ? {latch_q[31:2], 2'b00} : '1;
                if (fwd) begin
                    tgt_write <= io_write;
                    tgt_type1 <= route_t1;
                    tgt_bus   <= latch_q.bus;
                    tgt_dev   <= latch_q.dev;
                    tgt_func  <= latch_q.func;
                    tgt_reg   <= latch_q.regn;
                    tgt_be    <= io_be;
                    tgt_wdata <= io_wdata;
                end
            end
            unique case (state)
                ST_WAIT_INT: if (tgt_done[0]) resp_q <= tgt_rdata[31:0];
                ST_WAIT_HUB: if (tgt_done[1]) resp_q <= tgt_rdata[63:32];
                ST_WAIT_GFX: if (tgt_done[2]) resp_q <= tgt_rdata[95:64];
                default: ;
            endcase
        end
    end

    logic busy;
    assign busy = (state == ST_WAIT_INT) || (state == ST_WAIT_HUB) || (state == ST_WAIT_GFX);

    assert_onehot_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_req));

    assert_resp_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && |(tgt_req & tgt_done)) |=> io_resp_valid);

    assert_ready_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || io_resp_valid) |-> !io_req_ready);

    assert_no_req_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_data && !latch_q.en) |=> (tgt_req == 3'b000));

    assert_int_bus0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req[0] |-> (tgt_bus == '0 && !tgt_type1));

    assert_gfx_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fwd && route == RT_GFX) |=>
            (tgt_bus >= sec_bus && tgt_bus <= sub_bus && tgt_bus != '0));

endmodule

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router
    import cfg_router_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                N_INT_DEV = 2,
    parameter logic [ADDR_W-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_req_valid,
    output logic                 io_req_ready,
    input  logic                 io_write,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [3:0]           io_be,
    input  logic [31:0]          io_wdata,
    output logic                 io_resp_valid,
    output logic [31:0]          io_rdata,
    input  logic [N_INT_DEV-1:0] int_dev_en,
    input  logic [7:0]           sec_bus,
    input  logic [7:0]           sub_bus,
    output logic                 int_req,
    output logic                 hub_req,
    output logic                 gfx_req,
    output logic                 tgt_write,
    output logic                 tgt_type1,
    output logic [7:0]           tgt_bus,
    output logic [4:0]           tgt_dev,
    output logic [2:0]           tgt_func,
    output logic [5:0]           tgt_reg,
    output logic [3:0]           tgt_be,
    output logic [31:0]          tgt_wdata,
    input  logic                 int_done,
    input  logic [31:0]          int_rdata,
    input  logic                 hub_done,
    input  logic [31:0]          hub_rdata,
    input  logic                 gfx_done,
    input  logic [31:0]          gfx_rdata
);

    cfg_addr_t  latch_q;
    logic       latch_wr;
    route_e     route;
    logic       route_t1;
    logic [2:0] req_vec;

    cfg_addr_latch #(.DATA_W(32)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (latch_wr),
        .wr_be   (io_be),
        .wr_data (io_wdata),
        .q       (latch_q)
    );

    cfg_route_decode #(.N_INT_DEV(N_INT_DEV)) u_decode (
        .addr       (latch_q),
        .sec_bus    (sec_bus),
        .sub_bus    (sub_bus),
        .int_dev_en (int_dev_en),
        .route      (route),
        .type1      (route_t1)
    );

    cfg_router_fsm #(
        .ADDR_W    (ADDR_W),
        .ADDR_PORT (ADDR_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .io_req_valid  (io_req_valid),
        .io_req_ready  (io_req_ready),
        .io_write      (io_write),
        .io_addr       (io_addr),
        .io_be         (io_be),
        .io_wdata      (io_wdata),
        .io_resp_valid (io_resp_valid),
        .io_rdata      (io_rdata),
        .latch_q       (latch_q),
        .latch_wr      (latch_wr),
        .route         (route),
        .route_t1      (route_t1),
        .sec_bus       (sec_bus),
        .sub_bus       (sub_bus),
        .tgt_req       (req_vec),
        .tgt_write     (tgt_write),
        .tgt_type1     (tgt_type1),
        .tgt_bus       (tgt_bus),
        .tgt_dev       (tgt_dev),
        .tgt_func      (tgt_func),
        .tgt_reg       (tgt_reg),
        .tgt_be        (tgt_be),
        .tgt_wdata     (tgt_wdata),
        .tgt_done      ({gfx_done, hub_done, int_done}),
        .tgt_rdata     ({gfx_rdata, hub_rdata, int_rdata})
    );

    assign int_req = req_vec[0];
    assign hub_req = req_vec[1];
    assign gfx_req = req_vec[2];

endmodule

// File: tb/cfg_cycle_router_test.sv
module cfg_cycle_router_test;

    localparam logic [31:0] INT_RD = 32'hA0A0_0001;
    localparam logic [31:0] HUB_RD = 32'hB0B0_0002;
    localparam logic [31:0] GFX_RD = 32'hC0C0_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req_valid = 1'b0, io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        io_req_ready, io_resp_valid;
    logic [31:0] io_rdata;
    logic [1:0]  int_dev_en = 2'b11;
    logic [7:0]  sec_bus = 8'd0, sub_bus = 8'd0;
    logic        int_req, hub_req, gfx_req, tgt_write, tgt_type1;
    logic [7:0]  tgt_bus;
    logic [4:0]  tgt_dev;
    logic [2:0]  tgt_func;
    logic [5:0]  tgt_reg;
    logic [3:0]  tgt_be;
    logic [31:0] tgt_wdata;
    logic        int_done = 1'b0, hub_done = 1'b0, gfx_done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cfg_cycle_router uut (
        .clk(clk), .rst_n(rst_n),
        .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
        .io_write(io_write), .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
        .io_resp_valid(io_resp_valid), .io_rdata(io_rdata),
        .int_dev_en(int_dev_en), .sec_bus(sec_bus), .sub_bus(sub_bus),
        .int_req(int_req), .hub_req(hub_req), .gfx_req(gfx_req),
        .tgt_write(tgt_write), .tgt_type1(tgt_type1), .tgt_bus(tgt_bus),
        .tgt_dev(tgt_dev), .tgt_func(tgt_func), .tgt_reg(tgt_reg),
        .tgt_be(tgt_be), .tgt_wdata(tgt_wdata),
        .int_done(int_done), .int_rdata(INT_RD),
        .hub_done(hub_done), .hub_rdata(HUB_RD),
        .gfx_done(gfx_done), .gfx_rdata(GFX_RD)
    );

    // target models: answer after a fixed delay
    int rsp_cnt = 0;
    always @(posedge clk) begin
        int_done <= 1'b0; hub_done <= 1'b0; gfx_done <= 1'b0;
        if (int_req || hub_req || gfx_req) begin
            if (rsp_cnt == 2) begin
                rsp_cnt  <= 0;
                int_done <= int_req; hub_done <= hub_req; gfx_done <= gfx_req;
            end else begin
                rsp_cnt <= rsp_cnt + 1;
            end
        end else begin
            rsp_cnt <= 0;
        end
    end

    // monitor: count request starts, capture payload
    int   n_int = 0, n_hub = 0, n_gfx = 0;
    logic p_int = 0, p_hub = 0, p_gfx = 0;
    logic cap_t1, cap_wr;
    logic [7:0] cap_bus; logic [4:0] cap_dev; logic [2:0] cap_fn; logic [5:0] cap_reg;
    logic [3:0] cap_be; logic [31:0] cap_wd;
    always @(negedge clk) begin
        if (int_req && !p_int) n_int++;
        if (hub_req && !p_hub) n_hub++;
        if (gfx_req && !p_gfx) n_gfx++;
        p_int = int_req; p_hub = hub_req; p_gfx = gfx_req;
        if (int_req || hub_req || gfx_req) begin
            cap_t1 = tgt_type1; cap_wr = tgt_write; cap_bus = tgt_bus; cap_dev = tgt_dev;
            cap_fn = tgt_func; cap_reg = tgt_reg; cap_be = tgt_be; cap_wd = tgt_wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic io_xfer(input logic w, input logic [15:0] a, input logic [3:0] be,
                           input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        io_req_valid = 1'b1; io_write = w; io_addr = a; io_be = be; io_wdata = wd;
        while (!io_req_ready) @(negedge clk);
        @(negedge clk);
        io_req_valid = 1'b0;
        check(io_req_ready == 1'b0, "R12 ready low while busy", {31'd0, io_req_ready}, 32'd0);
        while (!io_resp_valid) @(negedge clk);
        rd = io_rdata;
        @(negedge clk);
    endtask

    task automatic set_latch(input logic [31:0] v);
        logic [31:0] d;
        io_xfer(1'b1, 16'h0CF8, 4'hF, v, d);
    endtask

    // load latch, do one window access, check route / type / data
    task automatic cfg_access(input logic [31:0] lv, input logic w, input logic [3:0] be,
                              input logic [31:0] wd, input logic [2:0] exp_mask,
                              input logic exp_t1, input logic [31:0] exp_rd, input string tag);
        int i0, h0, g0;
        logic [31:0] rd;
        logic [2:0] got;
        set_latch(lv);
        i0 = n_int; h0 = n_hub; g0 = n_gfx;
        io_xfer(w, 16'h0CFC + {14'd0, lv[1:0]}, be, wd, rd);
        got = {3'(n_gfx - g0 != 0), 3'(n_hub - h0 != 0), 3'(n_int - i0 != 0)};
        got = {got[6:4] != 0, got[3:2] != 0, got[0]};
        got = {(n_gfx != g0), (n_hub != h0), (n_int != i0)};
        check(got == exp_mask, {tag, " target"}, {29'd0, got}, {29'd0, exp_mask});
        if (exp_mask != 3'b000) begin
            check(cap_t1 == exp_t1, {tag, " type1"}, {31'd0, cap_t1}, {31'd0, exp_t1});
            check({cap_bus, cap_dev, cap_fn, cap_reg} == lv[23:2],
                  {tag, " R9 fields"}, {10'd0, cap_bus, cap_dev, cap_fn, cap_reg}, {10'd0, lv[23:2]});
            check(cap_wr == w && cap_be == be, {tag, " R9 write/be"},
                  {27'd0, cap_wr, cap_be}, {27'd0, w, be});
            if (w) check(cap_wd == wd, {tag, " R9 wdata"}, cap_wd, wd);
        end
        if (!w) check(rd == exp_rd, {tag, " R10 rdata"}, rd, exp_rd);
    endtask

    function automatic logic [31:0] cfa(input logic en, input logic [7:0] bus,
                                        input logic [4:0] dev, input logic [2:0] fn,
                                        input logic [5:0] rg);
        return {en, 7'd0, bus, dev, fn, rg, 2'b00};
    endfunction

    task automatic t_reset;
        logic [31:0] rd;
        check(io_req_ready == 1'b1 && io_resp_valid == 1'b0 && !int_req && !hub_req && !gfx_req,
              "R1 idle outputs", {28'd0, io_req_ready, io_resp_valid, int_req, hub_req}, 32'h8);
        io_xfer(1'b0, 16'h0CF8, 4'hF, 32'd0, rd);
        check(rd == 32'd0, "R1 latch reset", rd, 32'd0);
    endtask

    task automatic t_latch;
        logic [31:0] rd;
        set_latch(32'h8012_3457);
        io_xfer(1'b0, 16'h0CF8, 4'hF, 32'd0, rd);
        check(rd == 32'h8012_3454, "R2 readback low bits zero", rd, 32'h8012_3454);
        io_xfer(1'b1, 16'h0CF8, 4'h3, 32'h0000_FFFF, rd);
        io_xfer(1'b0, 16'h0CF8, 4'hF, 32'd0, rd);
        check(rd == 32'h8012_3454, "R2 partial write ignored", rd, 32'h8012_3454);
    endtask

    task automatic t_disabled;
        cfg_access(cfa(1'b0, 8'd0, 5'd1, 3'd0, 6'd0), 1'b0, 4'hF, 32'd0, 3'b000, 1'b0,
                   32'hFFFF_FFFF, "R3 read bit31 clear");
        cfg_access(cfa(1'b0, 8'd4, 5'd0, 3'd0, 6'd0), 1'b1, 4'hF, 32'h1234_5678, 3'b000, 1'b0,
                   32'd0, "R3 write bit31 clear");
    endtask

    task automatic t_internal;
        int_dev_en = 2'b11;
        cfg_access(cfa(1'b1, 8'd0, 5'd0, 3'd2, 6'h04), 1'b0, 4'hF, 32'd0, 3'b001, 1'b0,
                   INT_RD, "R4 dev0 internal");
        cfg_access(cfa(1'b1, 8'd0, 5'd1, 3'd0, 6'h3F), 1'b1, 4'b0110, 32'hDEAD_BEEF, 3'b001, 1'b0,
                   32'd0, "R4 dev1 internal write");
    endtask

    task automatic t_dev_off;
        int_dev_en = 2'b01;
        cfg_access(cfa(1'b1, 8'd0, 5'd1, 3'd1, 6'h02), 1'b0, 4'hF, 32'd0, 3'b010, 1'b0,
                   HUB_RD, "R5 disabled dev1 to hub");
        cfg_access(cfa(1'b1, 8'd0, 5'd0, 3'd0, 6'h02), 1'b0, 4'hF, 32'd0, 3'b001, 1'b0,
                   INT_RD, "R5 enabled dev0 stays internal");
        int_dev_en = 2'b11;
    endtask

    task automatic t_bus0_other;
        cfg_access(cfa(1'b1, 8'd0, 5'd5, 3'd3, 6'h01), 1'b0, 4'hF, 32'd0, 3'b010, 1'b0,
                   HUB_RD, "R6 bus0 dev5 hub type0");
    endtask

    task automatic t_range;
        cfg_access(cfa(1'b1, 8'd1, 5'd0, 3'd0, 6'd0), 1'b0, 4'hF, 32'd0, 3'b010, 1'b1,
                   HUB_RD, "R7 reset window bus1 hub");
        sec_bus = 8'd3; sub_bus = 8'd6;
        cfg_access(cfa(1'b1, 8'd2, 5'd3, 3'd0, 6'd0), 1'b0, 4'hF, 32'd0, 3'b010, 1'b1,
                   HUB_RD, "R7 below secondary");
        cfg_access(cfa(1'b1, 8'd7, 5'd3, 3'd0, 6'd0), 1'b0, 4'hF, 32'd0, 3'b010, 1'b1,
                   HUB_RD, "R7 above subordinate");
        cfg_access(cfa(1'b1, 8'd255, 5'd0, 3'd0, 6'd0), 1'b0, 4'hF, 32'd0, 3'b010, 1'b1,
                   HUB_RD, "R7 bus 255");
        cfg_access(cfa(1'b1, 8'd3, 5'd0, 3'd0, 6'h10), 1'b0, 4'hF, 32'd0, 3'b100, 1'b0,
                   GFX_RD, "R8 equals secondary type0");
        cfg_access(cfa(1'b1, 8'd6, 5'd9, 3'd7, 6'h20), 1'b0, 4'hF, 32'd0, 3'b100, 1'b1,
                   GFX_RD, "R8 equals subordinate type1");
        cfg_access(cfa(1'b1, 8'd4, 5'd1, 3'd0, 6'h00), 1'b1, 4'b1000, 32'h0BAD_F00D, 3'b100, 1'b1,
                   32'd0, "R8 inside window write");
    endtask

    task automatic t_other_addr;
        logic [31:0] rd;
        int i0, h0, g0;
        set_latch(cfa(1'b1, 8'd0, 5'd0, 3'd0, 6'd1));
        i0 = n_int; h0 = n_hub; g0 = n_gfx;
        io_xfer(1'b0, 16'h0080, 4'hF, 32'd0, rd);
        check(rd == 32'hFFFF_FFFF, "R11 unclaimed read", rd, 32'hFFFF_FFFF);
        io_xfer(1'b1, 16'h0CF0, 4'hF, 32'h0000_0000, rd);
        check(n_int == i0 && n_hub == h0 && n_gfx == g0, "R11 no target request",
              32'(n_int - i0 + n_hub - h0 + n_gfx - g0), 32'd0);
        io_xfer(1'b0, 16'h0CF8, 4'hF, 32'd0, rd);
        check(rd == 32'h8000_0004, "R11 latch unchanged", rd, 32'h8000_0004);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_disabled();
        t_internal();
        t_dev_off();
        t_bus0_other();
        t_range();
        t_other_addr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule